// File: doc/BRIEF.md
# Integer Execute Unit

This block is the integer execute stage of a small load/store processor. It is purely combinational. It takes a 4-bit operation code, two 32-bit register operands, a 16-bit immediate and a flag that chooses between the second register operand and the widened immediate. It returns a 32-bit result and a signed-overflow flag.

The block also evaluates four branch conditions in parallel with the arithmetic. Two of them test whether the first operand is zero. The other two follow a single-bit floating-point status input. The decode stage picks whichever branch condition it needs; the conditions do not depend on the operation code.

Top module: `exu_int_unit`

## Requirements
- R1: Operation codes are 0 = signed add, 1 = unsigned add, 2 = signed subtract, 3 = unsigned subtract, 4 = AND, 5 = OR, 6 = XOR and 7 = load-high. For codes 0 to 3 the result is the 32-bit sum or difference, wrapped modulo 2^32. This holds even when overflow is flagged.
- R2: For codes 0 and 2, `ovf_o` is 1 exactly when the true two's-complement result is greater than 2^31-1 or less than -2^31.
- R3: `ovf_o` is 0 for every code other than 0 and 2, including the unsigned add and subtract codes.
- R4: When `use_imm_i` is 1 and the code is 0 or 2, the immediate is sign-extended to 32 bits and used in place of `src_b_i`.
- R5: When `use_imm_i` is 1 and the code is 1, 3, 4, 5 or 6, the immediate is zero-extended to 32 bits and used in place of `src_b_i`.
- R6: Codes 4, 5 and 6 return the bitwise AND, OR and XOR of `src_a_i` and the selected second operand.
- R7: Code 7 returns the immediate in bits 31:16 and zeros in bits 15:0. `src_a_i`, `src_b_i` and `use_imm_i` have no effect on this result.
- R8: `br_zero_o` is 1 exactly when `src_a_i` is zero, and `br_nonzero_o` is always its complement.
- R9: `br_fp_true_o` equals `fp_flag_i`, and `br_fp_false_o` is always its complement.
- R10: Codes 8 to 15 return a zero result with `ovf_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | 1 selects the widened immediate as the second operand |
| fp_flag_i | input | 1 | Floating-point status bit |
| result_o | output | 32 | Execute result |
| ovf_o | output | 1 | Signed overflow |
| br_zero_o | output | 1 | First operand is zero |
| br_nonzero_o | output | 1 | First operand is nonzero |
| br_fp_true_o | output | 1 | Status bit is set |
| br_fp_false_o | output | 1 | Status bit is clear |

## Verification
The assertions hold on every input combination. They check the following:
- Overflow only appears for the two signed codes, and it always comes with a result whose sign differs from the first operand.
- Each pair of branch outputs is complementary.
- Load-high clears its low half.
- Undefined codes return zero.

Whether a sum is numerically right, and whether the extension mode matches the code, can only be shown by the bench. It compares the outputs against a wide-integer model across carry, wrap and sign-boundary operands.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_LHI  = 4'd7
  } exu_op_e;
endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel
  import exu_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int IMW = IMM_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    reg_b_i,
  input  logic [IMW-1:0]  imm_i,
  input  logic            use_imm_i,
  output logic [W-1:0]    operand_o
);
  localparam int EXT_W = W - IMW;

  logic          sext;
  logic [W-1:0]  imm_ext;

  // only the signed arithmetic codes sign-extend
  assign sext    = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign imm_ext = {{EXT_W{sext & imm_i[IMW-1]}}, imm_i};
  assign operand_o = use_imm_i ? imm_ext : reg_b_i;
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         sovf_o
);
  logic [W-1:0] b_eff;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign sum_o  = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  // same-sign inputs yielding opposite-sign output
  assign sovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/exu_logic.sv
module exu_logic
  import exu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  output logic [W-1:0]    out_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  out_o = a_i & b_i;
      OP_OR:   out_o = a_i | b_i;
      OP_XOR:  out_o = a_i ^ b_i;
      default: out_o = '0;
    endcase
  end
endmodule

// File: rtl/exu_branch_cond.sv
module exu_branch_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic         fp_flag_i,
  output logic         zero_o,
  output logic         nonzero_o,
  output logic         fp_true_o,
  output logic         fp_false_o
);
  assign zero_o     = (a_i == '0);
  assign nonzero_o  = ~zero_o;
  assign fp_true_o  = fp_flag_i;
  assign fp_false_o = ~fp_flag_i;
endmodule

// File: rtl/exu_int_unit.sv
module exu_int_unit
  import exu_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [XLEN-1:0]  src_a_i,
  input  logic [XLEN-1:0]  src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             fp_flag_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ovf_o,
  output logic             br_zero_o,
  output logic             br_nonzero_o,
  output logic             br_fp_true_o,
  output logic             br_fp_false_o
);
  localparam int LO_W = XLEN - IMM_W;

  logic [XLEN-1:0] opnd_b, sum, logic_out;
  logic            sovf, is_sub, is_signed, is_arith;

  assign is_sub    = (op_i == OP_SUB) || (op_i == OP_SUBU);
  assign is_signed = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign is_arith  = (op_i <= OP_SUBU);

  exu_operand_sel #(.W(XLEN), .IMW(IMM_W)) u_opsel (
    .op_i      (op_i),
    .reg_b_i   (src_b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .operand_o (opnd_b)
  );

  exu_addsub #(.W(XLEN)) u_addsub (
    .a_i    (src_a_i),
    .b_i    (opnd_b),
    .sub_i  (is_sub),
    .sum_o  (sum),
    .sovf_o (sovf)
  );

  exu_logic #(.W(XLEN)) u_logic (
    .op_i  (op_i),
    .a_i   (src_a_i),
    .b_i   (opnd_b),
    .out_o (logic_out)
  );

  exu_branch_cond #(.W(XLEN)) u_brc (
    .a_i        (src_a_i),
    .fp_flag_i  (fp_flag_i),
    .zero_o     (br_zero_o),
    .nonzero_o  (br_nonzero_o),
    .fp_true_o  (br_fp_true_o),
    .fp_false_o (br_fp_false_o)
  );

  always_comb begin
    if (is_arith)            result_o = sum;
    else if (op_i == OP_LHI) result_o = {imm_i, {LO_W{1'b0}}};
    else                     result_o = logic_out;
  end

  // overflow flag is informational; result keeps the wrapped value
  assign ovf_o = is_signed & sovf;
endmodule

// File: rtl/exu_int_unit_chk.sv
module exu_int_unit_chk
  import exu_pkg::*;
(
  input logic [OP_W-1:0]  op_i,
  input logic [XLEN-1:0]  src_a_i,
  input logic [XLEN-1:0]  result_o,
  input logic             ovf_o,
  input logic             br_zero_o,
  input logic             br_nonzero_o,
  input logic             br_fp_true_o,
  input logic             br_fp_false_o
);
  always_comb begin
    // R3
    no_overflow_chk: assert (!ovf_o || op_i == OP_ADD || op_i == OP_SUB);
    // R2
    ovf_sign_flip_chk: assert (!ovf_o || (result_o[XLEN-1] != src_a_i[XLEN-1]));
    // R8
    zero_pair_chk: assert (br_zero_o ^ br_nonzero_o);
    // R9
    fp_pair_chk: assert (br_fp_true_o ^ br_fp_false_o);
    // R7
    lhi_low_clear_chk: assert (op_i != OP_LHI || result_o[XLEN-IMM_W-1:0] == '0);
    // R10
    undef_op_chk: assert (op_i <= OP_LHI || (result_o == '0 && !ovf_o));
  end
endmodule

bind exu_int_unit exu_int_unit_chk u_chk (.*);

// File: tb/exu_int_unit_test.sv
module exu_int_unit_test;
  typedef struct {
    logic [31:0] res;
    logic        ovf, bz, bnz, ft, ff;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic [3:0]  op_i;
  logic [31:0] src_a_i, src_b_i;
  logic [15:0] imm_i;
  logic        use_imm_i, fp_flag_i;
  logic [31:0] result_o;
  logic        ovf_o, br_zero_o, br_nonzero_o, br_fp_true_o, br_fp_false_o;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  exu_int_unit uut (.*);

  function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, b,
                                 input logic [15:0] imm, input logic ui, fp, input string tag);
    exp_t e;
    logic [31:0] bb;
    longint sa, sb2, full;
    bb = b;
    if (ui) bb = ((op == 0 || op == 2) && imm[15]) ? (32'hFFFF0000 | 32'(imm)) : 32'(imm);
    e.res = 0; e.ovf = 0;
    sa = longint'($signed(a)); sb2 = longint'($signed(bb));
    case (op)
      0, 1: e.res = a + bb;
      2, 3: e.res = a - bb;
      4: e.res = a & bb;
      5: e.res = a | bb;
      6: e.res = a ^ bb;
      7: e.res = {imm, 16'h0};
      default: e.res = 0;
    endcase
    if (op == 0 || op == 2) begin
      full = (op == 0) ? sa + sb2 : sa - sb2;
      e.ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
    end
    e.bz = (a == 0); e.bnz = (a != 0); e.ft = fp; e.ff = !fp;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, b,
                       input logic [15:0] imm, input logic ui, fp, input string tag);
    @(posedge clk); #1;
    op_i = op; src_a_i = a; src_b_i = b; imm_i = imm; use_imm_i = ui; fp_flag_i = fp;
    sb.push_back(model(op, a, b, imm, ui, fp, tag));
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if ({result_o, ovf_o, br_zero_o, br_nonzero_o, br_fp_true_o, br_fp_false_o} !==
          {e.res, e.ovf, e.bz, e.bnz, e.ft, e.ff}) begin
        n_fail++;
        $display("FAIL %s: got res=%h ovf=%b br=%b%b%b%b exp res=%h ovf=%b br=%b%b%b%b",
                 e.tag, result_o, ovf_o, br_zero_o, br_nonzero_o, br_fp_true_o, br_fp_false_o,
                 e.res, e.ovf, e.bz, e.bnz, e.ft, e.ff);
      end
    end
  end

  initial begin
    op_i = 0; src_a_i = 0; src_b_i = 0; imm_i = 0; use_imm_i = 0; fp_flag_i = 0;
    drive(4'd0, 32'h0, 32'h0, 16'h0, 0, 0, "R8 idle state zero");
    drive(4'd0, 32'd5, 32'd7, 16'h0, 0, 0, "R1 add");
    drive(4'd0, 32'h7FFFFFFF, 32'd1, 16'h0, 0, 0, "R2 add pos ovf wraps");
    drive(4'd0, 32'h80000000, 32'hFFFFFFFF, 16'h0, 0, 1, "R2 add neg ovf");
    drive(4'd2, 32'h80000000, 32'd1, 16'h0, 0, 0, "R2 sub ovf");
    drive(4'd2, 32'd5, 32'd7, 16'h0, 0, 0, "R1 sub negative no ovf");
    drive(4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 0, 0, "R2 sub pos ovf");
    drive(4'd1, 32'hFFFFFFFF, 32'd1, 16'h0, 0, 0, "R3 addu carry out");
    drive(4'd3, 32'h0, 32'd1, 16'h0, 0, 1, "R3 subu borrow");
    drive(4'd0, 32'd10, 32'h12345678, 16'hFFFF, 1, 0, "R4 addi sign ext");
    drive(4'd2, 32'd1, 32'h0, 16'h8000, 1, 0, "R4 subi sign ext");
    drive(4'd0, 32'h7FFFFFFF, 32'h0, 16'h0001, 1, 0, "R4 addi ovf");
    drive(4'd1, 32'd10, 32'h0, 16'hFFFF, 1, 0, "R5 addui zero ext");
    drive(4'd3, 32'h00010000, 32'h0, 16'h8000, 1, 0, "R5 subui zero ext");
    drive(4'd4, 32'hFFFFFFFF, 32'h0, 16'hF0F0, 1, 0, "R5 andi zero ext");
    drive(4'd6, 32'hFFFF0000, 32'h0, 16'h8001, 1, 0, "R5 xori zero ext");
    drive(4'd4, 32'hF0F0A5A5, 32'h0FF0FFFF, 16'h0, 0, 0, "R6 and");
    drive(4'd5, 32'hF0F00000, 32'h0000A5A5, 16'h0, 0, 0, "R6 or");
    drive(4'd6, 32'hAAAA5555, 32'hFFFF0000, 16'h0, 0, 1, "R6 xor");
    drive(4'd7, 32'hDEADBEEF, 32'h12345678, 16'hABCD, 0, 0, "R7 lhi reg sel");
    drive(4'd7, 32'h1, 32'hFFFFFFFF, 16'h8001, 1, 1, "R7 lhi imm sel");
    drive(4'd5, 32'h00000001, 32'h0, 16'h0, 0, 0, "R8 nonzero a");
    drive(4'd4, 32'h80000000, 32'h0, 16'h0, 0, 1, "R9 fp set");
    drive(4'd8, 32'h7FFFFFFF, 32'h1, 16'h1234, 0, 0, "R10 op 8");
    drive(4'd15, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'hFFFF, 1, 1, "R10 op 15");
    @(posedge clk); @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 5000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule